// File: doc/BRIEF.md
# Serial Address-Match Wake-Up Controller

This block holds the control and interrupt logic of a two-wire serial channel that can also act as a bus slave. It keeps a byte-wide control register and a slave address register. It compares the byte currently held in the external shift register with the programmed address and shows the result as a live, read-only compare flag. It also picks the strobe that clocks the shifter. The bit shifter, the pad drivers and the start/stop detector sit outside the block. Each of them reports to it through single-cycle strobe inputs.

With wake-up off, the block raises a one-cycle interrupt pulse after every completed byte. With wake-up on, it stays silent until a start condition is seen. It then raises the pulse only if the first byte that follows matches the slave address. This lets the host sleep through traffic addressed to other devices. The block has no data stream crossing it, so all pins are plain level or strobe signals and nothing is held back by back-pressure.

Top module: `swake_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `irq`, `shift_tick` and `wr_err` are low.
- R2: A `cfg_wr` stores bit 7 (channel enable), bit 5 (wake-up), bits 4..2 (mode) and bits 1..0 (clock select). These read back from the same positions on `cfg_rdata`, and a write to bit 6 has no effect.
- R3: While enabled, `cfg_rdata[6]` is 1 exactly when the stored slave address equals `shreg`, and it follows `shreg` in the same cycle.
- R4: While bit 7 is 0, `cfg_rdata[6]` reads 0, no `irq` pulse is produced and `shift_tick` stays low.
- R5: With wake-up off, every `byte_done_stb` gives a one-cycle `irq` pulse in the following cycle, whatever the address compare shows.
- R6: With wake-up on, `irq` pulses after a `byte_done_stb` only if a `start_stb` came earlier and the compare flag is 1 in the strobe's cycle.
- R7: The first-byte window opened by `start_stb` closes at the next `byte_done_stb`, whether or not it matched. Clearing the enable bit also closes it, so later matching bytes give no pulse.
- R8: Clock select 00 or 01 passes `ext_clk_tick`, 10 passes `tmr_tick`, and 11 passes `pre_tick` to `shift_tick`, one cycle later.
- R9: In bus mode (mode bits 4..3 = 11) with clock select 10, `shift_tick` pulses on every 16th `tmr_tick` counted from enable, starting with the 16th.
- R10: A `shreg_wr` while wake-up is on sets the sticky `wr_err` the next cycle, and it stays set until reset. Such a write does not change the first-byte window, and it does not change the interrupt decision. With wake-up off, a `shreg_wr` leaves `wr_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback with live compare flag in bit 6 |
| addr_wr | input | 1 | Slave address register write strobe |
| addr_wdata | input | 8 | Slave address value |
| shreg | input | 8 | Current shift register contents |
| shreg_wr | input | 1 | Host write to the shift register |
| start_stb | input | 1 | Start condition detected |
| byte_done_stb | input | 1 | Byte transfer completed |
| ext_clk_tick | input | 1 | Edge strobe from the external clock pin |
| tmr_tick | input | 1 | Timer output strobe |
| pre_tick | input | 1 | Internal prescaler tap strobe |
| shift_tick | output | 1 | Selected shift clock strobe |
| irq | output | 1 | Transfer interrupt, one-cycle pulse |
| wr_err | output | 1 | Sticky flag for a shift register write during wake-up |

## Verification
The hardest case to reach is the one where the wake-up gate must refuse a byte that matches the address. This happens on a second byte after a start, or on a first byte after the channel was turned off and on again. The bench builds these sequences with explicit start, byte-done and enable-toggle strobes, and the address and shift values are held equal throughout. A byte that does not match is also sent right after a start, to show that it closes the window. The divide-by-16 path is reached only through the mode and clock-select combination. The bench drives a long train of timer strobes and checks the output after every one of them.

// File: rtl/swake_pkg.sv
package swake_pkg;
  typedef enum logic [1:0] {
    CK_PIN_A = 2'b00,
    CK_PIN_B = 2'b01,
    CK_TMR   = 2'b10,
    CK_PRE   = 2'b11
  } cksel_e;

  typedef struct packed {
    logic       en;
    logic       wup;
    logic [2:0] mode;
    cksel_e     cksel;
  } ctrl_t;

  localparam int REG_W  = 8;
  localparam int BIT_EN = 7;
  localparam int BIT_EQ = 6;
  localparam int BIT_WU = 5;
endpackage

// File: rtl/swake_regs.sv
module swake_regs
  import swake_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic [AW-1:0] shreg,
  output ctrl_t         ctrl,
  output logic          match,
  output logic [REG_W-1:0] rdata
);
  logic [AW-1:0] sva_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      sva_q <= '0;
    end else begin
      if (cfg_wr) begin
        ctrl.en    <= cfg_wdata[BIT_EN];
        ctrl.wup   <= cfg_wdata[BIT_WU];
        ctrl.mode  <= cfg_wdata[4:2];
        ctrl.cksel <= cksel_e'(cfg_wdata[1:0]);
      end
      if (addr_wr) sva_q <= addr_wdata;
    end
  end

  // compare flag is live and masked by the enable
  assign match = ctrl.en && (sva_q == shreg);
  assign rdata = {ctrl.en, match, ctrl.wup, ctrl.mode, ctrl.cksel};
endmodule

// File: rtl/swake_irq_gate.sv
module swake_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wup,
  input  logic match,
  input  logic start_stb,
  input  logic byte_done_stb,
  input  logic shreg_wr,
  output logic irq,
  output logic wr_err
);
  logic first_q;
  logic fire;

  always_comb begin
    fire = 1'b0;
    if (en && byte_done_stb) fire = wup ? (first_q && match) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      irq     <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      irq <= fire;
      if (!en)            first_q <= 1'b0;
      else if (start_stb) first_q <= 1'b1;
      else if (byte_done_stb) first_q <= 1'b0;
      if (wup && shreg_wr) wr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/swake_clk_sel.sv
module swake_clk_sel
  import swake_pkg::*;
#(
  parameter int DIV_LOG2 = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   bus_mode,
  input  cksel_e cksel,
  input  logic   ext_clk_tick,
  input  logic   tmr_tick,
  input  logic   pre_tick,
  output logic   shift_tick
);
  logic tmr_eff;
  logic sel;

  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tmr_eff = tmr_tick;
    end else begin : g_div
      logic [DIV_LOG2-1:0] cnt_q;
      logic divide;
      assign divide  = bus_mode && (cksel == CK_TMR);
      assign tmr_eff = divide ? (tmr_tick && (&cnt_q)) : tmr_tick;
      always_ff @(posedge clk) begin
        if (!rst_n || !en || !divide) cnt_q <= '0;
        else if (tmr_tick)            cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    unique case (cksel)
      CK_TMR:  sel = tmr_eff;
      CK_PRE:  sel = pre_tick;
      default: sel = ext_clk_tick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shift_tick <= 1'b0;
    else        shift_tick <= en && sel;
  end
endmodule

// File: rtl/swake_ctrl.sv
module swake_ctrl
  import swake_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DIV_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic [AW-1:0] shreg,
  input  logic          shreg_wr,
  input  logic          start_stb,
  input  logic          byte_done_stb,
  input  logic          ext_clk_tick,
  input  logic          tmr_tick,
  input  logic          pre_tick,
  output logic          shift_tick,
  output logic          irq,
  output logic          wr_err
);
  ctrl_t ctrl;
  logic  match;

  swake_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .shreg(shreg),
    .ctrl(ctrl), .match(match), .rdata(cfg_rdata)
  );

  swake_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .wup(ctrl.wup), .match(match),
    .start_stb(start_stb), .byte_done_stb(byte_done_stb), .shreg_wr(shreg_wr),
    .irq(irq), .wr_err(wr_err)
  );

  swake_clk_sel #(.DIV_LOG2(DIV_LOG2)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en),
    .bus_mode(ctrl.mode[2:1] == 2'b11), .cksel(ctrl.cksel),
    .ext_clk_tick(ext_clk_tick), .tmr_tick(tmr_tick), .pre_tick(pre_tick),
    .shift_tick(shift_tick)
  );
endmodule

// File: rtl/swake_ctrl_chk.sv
module swake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       byte_done_stb,
  input logic       irq,
  input logic       shift_tick,
  input logic       wr_err
);
  // R5
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(byte_done_stb));
  // R4
  off_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |=> !irq);
  // R4
  off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |=> !shift_tick);
  // R6
  wake_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(cfg_rdata[5])) |-> $past(cfg_rdata[6]));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
endmodule

bind swake_ctrl swake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .byte_done_stb(byte_done_stb),
  .irq(irq), .shift_tick(shift_tick), .wr_err(wr_err)
);

// File: tb/swake_ctrl_bench.sv
module swake_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, addr_wr = 0, shreg_wr = 0, start_stb = 0, byte_done_stb = 0;
  logic ext_clk_tick = 0, tmr_tick = 0, pre_tick = 0;
  logic [7:0] cfg_wdata = 0, addr_wdata = 0, shreg = 0;
  logic [7:0] cfg_rdata;
  logic shift_tick, irq, wr_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swake_ctrl u_swake_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_wdata = v; cfg_wr = 1; cyc(); cfg_wr = 0;
  endtask

  task automatic wsva(input logic [7:0] v);
    addr_wdata = v; addr_wr = 1; cyc(); addr_wr = 0;
  endtask

  task automatic start(); start_stb = 1; cyc(); start_stb = 0; endtask

  // byte end: irq visible right after the sampling edge, gone one cycle later
  task automatic byte_end(input string req, input logic exp);
    byte_done_stb = 1; cyc(); byte_done_stb = 0;
    chk(req, irq, exp);
    cyc();
    chk(req, irq, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 tick", shift_tick, 0);
    chk("R1 err", wr_err, 0);

    // R2 readback of every value, compare forced false, bit 6 ignored
    wsva(8'h5A); shreg = 8'hA5;
    for (int v = 0; v < 256; v++) begin
      wcfg(v[7:0]);
      chk("R2 readback", cfg_rdata, {v[7], 1'b0, v[5:0]});
    end

    // R3 compare sweep
    wcfg(8'h80);
    for (int a = 0; a < 256; a += 17) begin
      wsva(a[7:0]);
      for (int s = 0; s < 256; s++) begin
        shreg = s[7:0]; #1;
        chk("R3 compare", cfg_rdata[6], (a == s));
      end
    end

    // R4 disabled channel
    wsva(8'h3C); shreg = 8'h3C; wcfg(8'h03);
    chk("R4 flag low", cfg_rdata[6], 0);
    byte_end("R4 no irq", 0);
    pre_tick = 1; cyc(); pre_tick = 0;
    chk("R4 no tick", shift_tick, 0);

    // R5 wake-up off: every byte interrupts, match or not
    wcfg(8'h80);
    byte_end("R5 match", 1);
    shreg = 8'h00;
    byte_end("R5 mismatch", 1);
    byte_end("R5 repeat", 1);

    // R6 / R7 wake-up on
    wcfg(8'hA0); shreg = 8'h3C;
    byte_end("R6 no start", 0);
    start(); byte_end("R6 first match", 1);
    byte_end("R7 second byte", 0);
    start(); shreg = 8'h11; byte_end("R6 first mismatch", 0);
    shreg = 8'h3C; byte_end("R7 closed after mismatch", 0);
    start(); wcfg(8'h20); wcfg(8'hA0);
    byte_end("R7 disable closes", 0);

    // R10 shift register write
    do_reset(); wsva(8'h3C); shreg = 8'h3C;
    wcfg(8'h80); shreg_wr = 1; cyc(); shreg_wr = 0;
    chk("R10 no err wup off", wr_err, 0);
    wcfg(8'hA0); start();
    shreg_wr = 1; cyc(); shreg_wr = 0;
    chk("R10 err set", wr_err, 1);
    byte_end("R10 irq unaffected", 1);
    wcfg(8'h80);
    chk("R10 sticky", wr_err, 1);

    // R8 clock source per select value
    for (int c = 0; c < 4; c++) begin
      wcfg(8'h80 | c[7:0]);
      for (int s = 0; s < 3; s++) begin
        ext_clk_tick = (s == 0); tmr_tick = (s == 1); pre_tick = (s == 2);
        cyc();
        ext_clk_tick = 0; tmr_tick = 0; pre_tick = 0;
        chk("R8 source", shift_tick, (c < 2) ? (s == 0) : (c == 2) ? (s == 1) : (s == 2));
        cyc();
        chk("R8 one cycle", shift_tick, 0);
      end
    end

    // R9 bus mode divides the timer source by 16
    wcfg(8'h00); wcfg(8'h80 | 8'h18 | 8'h02);
    for (int i = 0; i < 64; i++) begin
      tmr_tick = 1; cyc(); tmr_tick = 0;
      chk("R9 divide", shift_tick, (i % 16) == 15);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule